// File: doc/BRIEF.md
# Masked Vector Exponent Extractor

This block applies a per-element exponent extraction to a packed vector of 32-bit single-precision values. Each element is replaced by floor(log2(|x|)), written back as a single-precision number. Special inputs follow fixed rules: NaNs are quietened, infinities give +infinity, zeros give -infinity, and subnormals are normalised before their exponent is taken. One instance of the per-element unit sits in each lane.

A lane-count code selects 4, 8 or 16 active lanes. Lane j occupies bits [32j+31:32j]. Results are committed into a destination register that the block holds itself. A per-lane write mask controls which lanes take a new value. A masked-off lane either keeps its old value (merge policy) or is cleared (zero policy). Broadcast of element 0 to every lane is available for memory-sourced operands. Lanes above the active length are always cleared.

Invalid and denormal indications from the lanes that are actually written are ORed into two vector flags. A reserved 4-bit specifier field and the lane-count code are screened, and an illegal encoding is reported instead of being executed.

Top module: `vecMaskWrap`

## Requirements
- R1: A normal input with biased exponent e (1..254) yields the single-precision encoding of the integer e-127, where 0 is encoded as 0x00000000. The sign of the input is ignored, and no flag is raised.
- R2: A subnormal input (exponent field 0, fraction nonzero) whose highest set fraction bit is at position p (0..22) yields the encoding of p-149 and raises the denormal flag.
- R3: A NaN input (exponent field 255, fraction nonzero) yields the input with fraction bit 22 forced to 1. It raises the invalid flag exactly when that bit was 0 on input.
- R4: An infinity of either sign yields 0x7F800000, and a zero of either sign yields 0xFF800000. Neither raises a flag.
- R5: The lane-count code vecLen = 0, 1 or 2 activates 4, 8 or 16 lanes. After a commit, every destination lane at or above the active count reads zero.
- R6: With maskEn = 0, every active lane is written with its lane result, whatever kMask holds.
- R7: With maskEn = 1 and zeroMode = 0, an active lane whose kMask bit is 0 keeps its previous destination value.
- R8: With maskEn = 1 and zeroMode = 1, an active lane whose kMask bit is 0 is written with zero.
- R9: When bcastEn and srcIsMem are both 1, every active lane operates on srcVec[31:0]. With bcastEn = 1 and srcIsMem = 0, each lane uses its own element.
- R10: excInvalid and excDenorm are the OR of the lane flags of active lanes that are written. Masked-off and inactive lanes contribute nothing.
- R11: An accepted strobe with regSpec != 4'b1111 or vecLen = 3 is illegal. It raises illegal with done, leaves destVec unchanged and clears both flags.
- R12: After reset destVec, the flags, done and illegal are 0. done is high for exactly the one cycle after each cycle in which inValid is high, and destVec changes only in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| vecLen | input | 2 | Lane-count code: 0=4, 1=8, 2=16 lanes, 3 illegal |
| maskEn | input | 1 | Write mask in use |
| zeroMode | input | 1 | 1 clears masked-off lanes, 0 keeps them |
| bcastEn | input | 1 | Broadcast request |
| srcIsMem | input | 1 | Operand came from memory |
| regSpec | input | 4 | Reserved specifier field, must be 4'b1111 |
| kMask | input | 16 | Per-lane write mask |
| srcVec | input | 512 | Packed source elements |
| destVec | output | 512 | Registered destination vector |
| excInvalid | output | 1 | Invalid flag of the last operation |
| excDenorm | output | 1 | Denormal flag of the last operation |
| done | output | 1 | Result strobe, one cycle after inValid |
| illegal | output | 1 | Last operation was an illegal encoding |

## Verification
The lane function is swept over every biased exponent with varied fractions and signs, over subnormals with each leading-bit position, and over quiet and signalling NaNs, infinities and zeros. This separates the normal, subnormal and special-case paths and the exact flag conditions. All 16 mask values are applied at the 4-lane length under both merge and zero policies over a previously written destination, and a subset at 8 lanes. This separates keeping an old value from clearing it and shows which lanes feed the flags. Broadcast with and without the memory qualifier, every illegal specifier value and the reserved length code complete the set.

// File: rtl/vecPkg.sv
package vecPkg;
  localparam int LANE_W = 32;
  localparam int BASE_LANES = 4;

  typedef struct packed {
    logic commit;
    logic reject;
  } ctrlStrobe_t;
endpackage

// File: rtl/expLane.sv
module expLane (
  input  logic [31:0] opIn,
  output logic [31:0] resOut,
  output logic        invFlag,
  output logic        denFlag
);
  localparam int FRAC_W = 23;
  localparam int EXP_W = 8;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic signed [9:0] BIAS = 10'sd127;
  localparam logic signed [9:0] SUB_BASE = 10'sd149;

  logic [EXP_W-1:0] bexp;
  logic [FRAC_W-1:0] frac;
  logic signed [9:0] unb;
  logic [7:0] mag;
  logic [2:0] magTop;
  logic [FRAC_W-1:0] fracOut;
  logic [31:0] intAsFloat;

  function automatic logic [4:0] topBit23(input logic [FRAC_W-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < FRAC_W; i++) if (v[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [2:0] topBit8(input logic [7:0] v);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  assign bexp = opIn[30:23];
  assign frac = opIn[22:0];

  always_comb begin
    if (bexp == '0) unb = $signed({5'b0, topBit23(frac)}) - SUB_BASE;
    else            unb = $signed({2'b0, bexp}) - BIAS;
  end

  always_comb begin
    mag = unb[9] ? 8'(-unb) : unb[7:0];
    magTop = topBit8(mag);
    fracOut = 23'({23'b0, mag} << (5'd23 - {2'b0, magTop}));
    if (mag == '0) intAsFloat = '0;
    else intAsFloat = {unb[9], 8'd127 + {5'b0, magTop}, fracOut};
  end

  always_comb begin
    invFlag = 1'b0;
    denFlag = 1'b0;
    if (bexp == EXP_MAX) begin
      if (frac != '0) begin
        resOut = {opIn[31:23], 1'b1, opIn[21:0]};
        invFlag = ~frac[22];
      end else begin
        resOut = 32'h7F80_0000;
      end
    end else if (bexp == '0 && frac == '0) begin
      resOut = 32'hFF80_0000;
    end else begin
      resOut = intAsFloat;
      denFlag = (bexp == '0);
    end
  end
endmodule

// File: rtl/vecCtrl.sv
module vecCtrl
  import vecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [3:0]  regSpec,
  input  logic [1:0]  vecLen,
  output ctrlStrobe_t strobe,
  output logic        done,
  output logic        illegal
);
  localparam logic [3:0] SPEC_OK = 4'b1111;
  localparam logic [1:0] LEN_RSVD = 2'd3;

  logic encOk;
  assign encOk = (regSpec == SPEC_OK) && (vecLen != LEN_RSVD);

  always_comb begin
    strobe.commit = inValid && encOk;
    strobe.reject = inValid && !encOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= inValid;
      illegal <= strobe.reject;
    end
  end
endmodule

// File: rtl/vecDatapath.sv
module vecDatapath
  import vecPkg::*;
#(
  parameter int MAX_LANES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [1:0]                    vecLen,
  input  logic                          maskEn,
  input  logic                          zeroMode,
  input  logic                          bcastSel,
  input  logic [MAX_LANES-1:0]          kMask,
  input  logic [MAX_LANES*LANE_W-1:0]   srcVec,
  output logic [MAX_LANES*LANE_W-1:0]   destVec,
  output logic                          excInvalid,
  output logic                          excDenorm
);
  localparam int VEC_W = MAX_LANES * LANE_W;
  localparam int CNT_W = $clog2(MAX_LANES) + 2;

  logic [CNT_W-1:0] activeCount;
  logic [MAX_LANES-1:0] laneActive, laneWrite, laneInv, laneDen;
  logic [VEC_W-1:0] nextDest;

  assign activeCount = CNT_W'(BASE_LANES) << vecLen;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [LANE_W-1:0] laneSrc, laneRes, laneOld;
    assign laneSrc = bcastSel ? srcVec[LANE_W-1:0] : srcVec[j*LANE_W +: LANE_W];
    assign laneOld = destVec[j*LANE_W +: LANE_W];

    expLane u_lane (
      .opIn   (laneSrc),
      .resOut (laneRes),
      .invFlag(laneInv[j]),
      .denFlag(laneDen[j])
    );

    assign laneActive[j] = CNT_W'(j) < activeCount;
    assign laneWrite[j] = laneActive[j] && (!maskEn || kMask[j]);

    always_comb begin
      if (!laneActive[j])    nextDest[j*LANE_W +: LANE_W] = '0;
      else if (laneWrite[j]) nextDest[j*LANE_W +: LANE_W] = laneRes;
      else if (zeroMode)     nextDest[j*LANE_W +: LANE_W] = '0;
      else                   nextDest[j*LANE_W +: LANE_W] = laneOld;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destVec <= '0;
      excInvalid <= 1'b0;
      excDenorm <= 1'b0;
    end else if (strobe.commit) begin
      destVec <= nextDest;
      excInvalid <= |(laneInv & laneWrite);
      excDenorm <= |(laneDen & laneWrite);
    end else if (strobe.reject) begin
      excInvalid <= 1'b0;
      excDenorm <= 1'b0;
    end
  end
endmodule

// File: rtl/vecMaskWrap.sv
module vecMaskWrap
  import vecPkg::*;
#(
  parameter int MAX_LANES = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [1:0]                  vecLen,
  input  logic                        maskEn,
  input  logic                        zeroMode,
  input  logic                        bcastEn,
  input  logic                        srcIsMem,
  input  logic [3:0]                  regSpec,
  input  logic [MAX_LANES-1:0]        kMask,
  input  logic [MAX_LANES*32-1:0]     srcVec,
  output logic [MAX_LANES*32-1:0]     destVec,
  output logic                        excInvalid,
  output logic                        excDenorm,
  output logic                        done,
  output logic                        illegal
);
  ctrlStrobe_t strobe;

  vecCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .regSpec(regSpec),
    .vecLen (vecLen),
    .strobe (strobe),
    .done   (done),
    .illegal(illegal)
  );

  vecDatapath #(.MAX_LANES(MAX_LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .vecLen    (vecLen),
    .maskEn    (maskEn),
    .zeroMode  (zeroMode),
    .bcastSel  (bcastEn && srcIsMem),
    .kMask     (kMask),
    .srcVec    (srcVec),
    .destVec   (destVec),
    .excInvalid(excInvalid),
    .excDenorm (excDenorm)
  );
endmodule

// File: rtl/vecMaskWrapChk.sv
module vecMaskWrapChk #(
  parameter int MAX_LANES = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [1:0]              vecLen,
  input logic [3:0]              regSpec,
  input logic [MAX_LANES*32-1:0] destVec,
  input logic                    excInvalid,
  input logic                    excDenorm,
  input logic                    done,
  input logic                    illegal
);
  // R12
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> done);

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !done);

  // R12
  dest_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(destVec));

  // R11
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && regSpec != 4'b1111) |=> (illegal && destVec == $past(destVec)));

  // R11
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!excInvalid && !excDenorm));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vecLen == 2'd0 && regSpec == 4'b1111) |=> (destVec[MAX_LANES*32-1:128] == '0));
endmodule

bind vecMaskWrap vecMaskWrapChk #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .vecLen    (vecLen),
  .regSpec   (regSpec),
  .destVec   (destVec),
  .excInvalid(excInvalid),
  .excDenorm (excDenorm),
  .done      (done),
  .illegal   (illegal)
);

// File: tb/vecMaskWrap_bench.sv
module vecMaskWrap_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] vecLen = '0;
  logic maskEn = 1'b0, zeroMode = 1'b0, bcastEn = 1'b0, srcIsMem = 1'b0;
  logic [3:0] regSpec = 4'hF;
  logic [15:0] kMask = '0;
  logic [511:0] srcVec = '0;
  logic [511:0] destVec;
  logic excInvalid, excDenorm, done, illegal;

  int total = 0;
  int bad = 0;
  logic [511:0] model = '0;

  always #2.5 clk = ~clk;

  vecMaskWrap u_vecMaskWrap (
    .clk(clk), .rstN(rstN), .inValid(inValid), .vecLen(vecLen),
    .maskEn(maskEn), .zeroMode(zeroMode), .bcastEn(bcastEn), .srcIsMem(srcIsMem),
    .regSpec(regSpec), .kMask(kMask), .srcVec(srcVec), .destVec(destVec),
    .excInvalid(excInvalid), .excDenorm(excDenorm), .done(done), .illegal(illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] intToSp(input int n);
    logic [63:0] b;
    logic [10:0] e;
    if (n == 0) return 32'h0;
    b = $realtobits(real'(n));
    e = b[62:52] - 11'd896;
    return {b[63], e[7:0], b[51:29]};
  endfunction

  // returns {result, invalid, denormal}
  function automatic logic [33:0] refLane(input logic [31:0] x);
    logic [7:0] e;
    logic [22:0] f;
    int n;
    int v;
    e = x[30:23];
    f = x[22:0];
    if (e == 8'hFF && f != 0) return {x[31:23], 1'b1, x[21:0], ~f[22], 1'b0};
    if (e == 8'hFF) return {32'h7F80_0000, 2'b00};
    if (e == 0 && f == 0) return {32'hFF80_0000, 2'b00};
    if (e == 0) begin
      n = -149;
      v = int'(f);
      while (v >= 2) begin v = v / 2; n++; end
      return {intToSp(n), 2'b01};
    end
    return {intToSp(int'(e) - 127), 2'b00};
  endfunction

  task automatic runOp(input logic [1:0] vl, input logic me, input logic zm, input logic bc,
                       input logic mem, input logic [3:0] spec, input logic [15:0] k,
                       input logic [511:0] src, input string tag);
    logic [511:0] expD;
    logic expInv, expDen, legal;
    logic [33:0] r;
    int nl;
    legal = (spec == 4'hF) && (vl != 2'd3);
    expD = model;
    expInv = 1'b0;
    expDen = 1'b0;
    if (legal) begin
      nl = 4 << vl;
      for (int j = 0; j < 16; j++) begin
        if (j >= nl) expD[j*32 +: 32] = '0;
        else if (!me || k[j]) begin
          r = refLane((bc && mem) ? src[31:0] : src[j*32 +: 32]);
          expD[j*32 +: 32] = r[33:2];
          expInv |= r[1];
          expDen |= r[0];
        end else if (zm) expD[j*32 +: 32] = '0;
      end
    end
    @(negedge clk);
    vecLen = vl; maskEn = me; zeroMode = zm; bcastEn = bc; srcIsMem = mem;
    regSpec = spec; kMask = k; srcVec = src; inValid = 1'b1;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    check(destVec === expD, tag, destVec, expD);
    check({excInvalid, excDenorm} === {expInv, expDen}, {"R10 flags ", tag},
          512'({excInvalid, excDenorm}), 512'({expInv, expDen}));
    check(done === 1'b1, "R12 done", 512'(done), 512'(1));
    check(illegal === !legal, "R11 illegal", 512'(illegal), 512'(!legal));
    model = expD;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R12 act=%h exp=%h", 0, 1);
    summary();
  end

  initial begin
    logic [511:0] s;
    repeat (3) @(posedge clk);
    #1;
    check(destVec === '0 && done === 1'b0 && illegal === 1'b0 && excInvalid === 1'b0 && excDenorm === 1'b0,
          "R12 reset", destVec, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R4: every biased exponent, 16 per operation
    for (int b = 0; b < 16; b++) begin
      for (int j = 0; j < 16; j++)
        s[j*32 +: 32] = {1'(j), 8'(b*16 + j), 23'($urandom)};
      runOp(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0, s, "R1 R2 R3 R4 exponent sweep");
    end
    // R2: subnormal leading-bit positions
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 16; j++) begin
        int p;
        p = (b * 16 + j) % 23;
        s[j*32 +: 32] = {1'(b), 8'h00, 23'(1) << p | (23'($urandom) & ((23'(1) << p) - 23'(1)))};
      end
      runOp(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0, s, "R2 subnormal");
    end
    // R3 / R4: NaNs, infinities, zeros
    for (int j = 0; j < 16; j++)
      case (j % 4)
        0: s[j*32 +: 32] = {1'(j / 4), 8'hFF, 1'b0, 22'($urandom) | 22'h1};
        1: s[j*32 +: 32] = {1'(j / 4), 8'hFF, 1'b1, 22'($urandom)};
        2: s[j*32 +: 32] = {1'(j / 8), 31'h7F80_0000};
        default: s[j*32 +: 32] = {1'(j / 8), 31'h0};
      endcase
    runOp(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0, s, "R3 R4 specials");
    // R3 quiet NaN only: no invalid flag
    for (int j = 0; j < 16; j++) s[j*32 +: 32] = {1'b0, 8'hFF, 1'b1, 22'($urandom)};
    runOp(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0, s, "R3 quiet NaN");

    // R5 / R6: lengths with mask disabled and garbage mask
    for (int v = 0; v < 3; v++) begin
      for (int j = 0; j < 16; j++) s[j*32 +: 32] = $urandom;
      runOp(2'(v), 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 16'($urandom), s, "R5 R6 length");
    end

    // R7 / R8 / R10: all masks at 4 lanes, both policies, over a filled destination
    for (int z = 0; z < 2; z++)
      for (int m = 0; m < 16; m++) begin
        for (int j = 0; j < 16; j++) s[j*32 +: 32] = 32'h7F80_0000;
        runOp(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0, s, "R6 fill");
        for (int j = 0; j < 16; j++)
          s[j*32 +: 32] = (j % 2 == 0) ? {1'b0, 8'hFF, 1'b0, 22'h5} : {1'b0, 8'h00, 23'h40};
        runOp(2'd0, 1'b1, 1'(z), 1'b0, 1'b0, 4'hF, 16'(m) | 16'hFFF0, s,
              z ? "R8 zeroing R10" : "R7 merging R10");
      end
    // 8 lanes, mixed masks
    for (int m = 0; m < 8; m++) begin
      for (int j = 0; j < 16; j++) s[j*32 +: 32] = $urandom;
      runOp(2'd1, 1'b1, 1'(m % 2), 1'b0, 1'b0, 4'hF, 16'($urandom), s, "R7 R8 eight lanes");
    end

    // R9: broadcast
    for (int j = 0; j < 16; j++) s[j*32 +: 32] = $urandom;
    s[31:0] = {1'b1, 8'h00, 23'h1};
    runOp(2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 16'h0, s, "R9 broadcast");
    runOp(2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 16'h0, s, "R9 no broadcast from register");
    runOp(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 16'h00A5, s, "R9 broadcast masked");

    // R11: every bad specifier and the reserved length
    for (int sp = 0; sp < 15; sp++) begin
      for (int j = 0; j < 16; j++) s[j*32 +: 32] = {1'b0, 8'hFF, 23'h1};
      runOp(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'(sp), 16'h0, s, "R11 bad specifier");
    end
    runOp(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 16'h0, s, "R11 reserved length");

    // R12: done drops after a single cycle and destVec holds while idle
    s = destVec;
    @(posedge clk);
    #1;
    check(done === 1'b0, "R12 done single cycle", 512'(done), 512'(0));
    repeat (3) @(posedge clk);
    #1;
    check(destVec === s, "R12 idle hold", destVec, s);

    summary();
  end
endmodule